// File: doc/BRIEF.md
# Exception Control Register Set

This block holds the small group of privileged control registers that a processor core consults and updates when it takes an exception. When the core raises an exception strobe, the block records in one clock edge the return address (the address of the instruction after the faulting one), a kind code and, when needed, the offending data address. In the same edge it moves the processor into kernel mode with interrupts off and pushes the prior mode and enable bits onto a small stack kept in the status register. A return strobe pops that stack.

Privileged software reaches the registers through a read/write port addressed by register number. Only the status register can be written, and only while the block is in kernel mode. The status register also carries one enable bit for each interrupt line. The block combines these bits with the current global enable into a single interrupt request for the core.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After reset, every register reads as zero, `kernelMode` is 1 and `irqReq` is 0 whatever `irqLines` carries.
- R2: Register numbers are fixed: 8 is the faulting-address register, 12 is status, 13 is cause and 14 is the return address. Any other number reads as zero.
- R3: One cycle after `excStrobe`, the return-address register holds `excPc + 4`, computed modulo 2^32.
- R4: One cycle after `excStrobe`, the cause register holds `excCode` in bits 6:2 and zeros in every other bit. For example, overflow (code 12) reads as 0x30 and address error on load (code 4) reads as 0x10.
- R5: The faulting-address register loads `faultAddr` on an exception only when `faultAddrValid` is 1, the block was in user mode and `faultAddr` >= 0x80000000. In every other case it keeps its value.
- R6: Status bit 0 is the global interrupt enable and bit 1 is user mode (1 = user), with bits 3:2 as the previous pair and bits 5:4 as the older pair. An exception sets bits 5:4 to the old 3:2, bits 3:2 to the old 1:0, and bits 1:0 to 0.
- R7: `retStrobe` sets status bits 1:0 to the old 3:2 and bits 3:2 to the old 5:4, and leaves bits 5:4 unchanged.
- R8: A port write takes effect only when the register number is 12 and the block is in kernel mode. Only status bits 5:0 and 15:8 are kept, and the other bits read as zero. Writes to 8, 13 or 14, and any write made in user mode, leave every register unchanged.
- R9: `irqReq` equals status bit 0 AND the OR over i of (`irqLines[i]` AND status bit 8+i). It is combinational.
- R10: When the strobes coincide, an exception takes precedence over a return, and a return takes precedence over a port write. Only the winner changes status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| excStrobe | input | 1 | Core reports an exception this cycle |
| excCode | input | 5 | Exception kind code |
| excPc | input | 32 | Address of the faulting instruction |
| faultAddr | input | 32 | Data address involved in the fault |
| faultAddrValid | input | 1 | `faultAddr` is meaningful |
| retStrobe | input | 1 | Return from exception |
| regSel | input | 5 | Register number for the port |
| regWrEn | input | 1 | Port write enable |
| regWrData | input | 32 | Port write data |
| regRdData | output | 32 | Port read data, combinational on `regSel` |
| kernelMode | output | 1 | 1 while in kernel mode |
| irqLines | input | 8 | Pending interrupt lines |
| irqReq | output | 1 | Masked, globally enabled interrupt request |

## Verification
A wrong stack shift shows up at the ports one cycle after an exception or return. It appears as a bad `kernelMode` level and as `irqReq` rising while handler code should be shielded, and it can stay hidden until a second, nested exception exposes the older pair. A faulting-address register that latches in the wrong mode or at the wrong boundary changes nothing but its own readback. The bench therefore reads every register after each event and walks the address boundary on both sides. Write protection and strobe precedence can only be seen by reading status back right after the event, so the bench does that.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

  // strobes from the control decode to the register datapath
  typedef struct packed {
    logic takeExc;
    logic doRet;
    logic wrStatus;
    logic latchBad;
  } excCtl_t;

  // register numbers decoded by privileged software
  localparam int unsigned REG_FAULTADDR = 8;
  localparam int unsigned REG_STATUS    = 12;
  localparam int unsigned REG_CAUSE     = 13;
  localparam int unsigned REG_RETADDR   = 14;

  // status word layout
  localparam int unsigned ST_STACK_W = 6;   // three {user, ie} pairs
  localparam int unsigned ST_IE_BIT  = 0;
  localparam int unsigned ST_USR_BIT = 1;
  localparam int unsigned ST_MASK_LO = 8;

endpackage

// File: rtl/exc_ctrl_decode.sv
module exc_ctrl_decode
  import exc_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 5,
  parameter logic [DATA_W-1:0] KREGION_BASE = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              excStrobe,
  input  logic              retStrobe,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              faultAddrValid,
  input  logic [DATA_W-1:0] faultAddr,
  input  logic              curUser,
  output excCtl_t           ctl
);

  logic selStatus;
  logic inKernelRegion;

  assign selStatus      = (regSel == SEL_W'(REG_STATUS));
  assign inKernelRegion = (faultAddr >= KREGION_BASE);

  always_comb begin
    ctl          = '0;
    ctl.takeExc  = excStrobe;
    ctl.doRet    = retStrobe && !excStrobe;
    ctl.wrStatus = regWrEn && selStatus && !curUser && !excStrobe && !retStrobe;
    ctl.latchBad = excStrobe && curUser && faultAddrValid && inKernelRegion;
  end

  // at most one source updates the status stack in a cycle
  p_single_status_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.takeExc, ctl.doRet, ctl.wrStatus}));

  // no port write leaks through while in user mode
  p_user_write_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    curUser |-> !ctl.wrStatus);

endmodule

// File: rtl/exc_ctrl_dpath.sv
module exc_ctrl_dpath
  import exc_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned SEL_W     = 5,
  parameter int unsigned IRQ_W     = 8,
  parameter int unsigned PC_STEP   = 4,
  parameter int unsigned CAUSE_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  excCtl_t           ctl,
  input  logic [CODE_W-1:0] excCode,
  input  logic [DATA_W-1:0] excPc,
  input  logic [DATA_W-1:0] faultAddr,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [IRQ_W-1:0]  irqLines,
  output logic [DATA_W-1:0] regRdData,
  output logic              curUser,
  output logic              irqReq
);

  localparam int unsigned MASK_HI = ST_MASK_LO + IRQ_W - 1;

  logic [DATA_W-1:0]     retAddr;
  logic [CODE_W-1:0]     causeCode;
  logic [DATA_W-1:0]     badAddr;
  logic [ST_STACK_W-1:0] stk;
  logic [IRQ_W-1:0]      irqMask;
  logic [IRQ_W-1:0]      maskedLines;
  logic [DATA_W-1:0]     statusWord;
  logic [DATA_W-1:0]     causeWord;

  // saved-state registers: written only on an exception
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retAddr   <= '0;
      causeCode <= '0;
    end else if (ctl.takeExc) begin
      retAddr   <= excPc + DATA_W'(PC_STEP);
      causeCode <= excCode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            badAddr <= '0;
    else if (ctl.latchBad) badAddr <= faultAddr;
  end

  // mode / enable stack and interrupt mask
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stk     <= '0;
      irqMask <= '0;
    end else if (ctl.takeExc) begin
      stk <= {stk[3:0], 2'b00};
    end else if (ctl.doRet) begin
      stk <= {stk[5:4], stk[5:2]};
    end else if (ctl.wrStatus) begin
      stk     <= regWrData[ST_STACK_W-1:0];
      irqMask <= regWrData[MASK_HI:ST_MASK_LO];
    end
  end

  for (genvar i = 0; i < IRQ_W; i++) begin : g_irq
    assign maskedLines[i] = irqLines[i] & irqMask[i];
  end

  assign irqReq  = stk[ST_IE_BIT] & (|maskedLines);
  assign curUser = stk[ST_USR_BIT];

  always_comb begin
    statusWord                      = '0;
    statusWord[ST_STACK_W-1:0]      = stk;
    statusWord[MASK_HI:ST_MASK_LO]  = irqMask;
    causeWord                       = '0;
    causeWord[CAUSE_LSB +: CODE_W]  = causeCode;
  end

  always_comb begin
    unique case (regSel)
      SEL_W'(REG_FAULTADDR): regRdData = badAddr;
      SEL_W'(REG_STATUS):    regRdData = statusWord;
      SEL_W'(REG_CAUSE):     regRdData = causeWord;
      SEL_W'(REG_RETADDR):   regRdData = retAddr;
      default:               regRdData = '0;
    endcase
  end

  // an exception always lands in kernel mode with interrupts off
  p_exc_enters_kernel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.takeExc |=> (!curUser && !irqReq));

  // the return address follows the faulting instruction
  p_retaddr_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.takeExc |=> (retAddr == $past(excPc) + DATA_W'(PC_STEP)));

  // the faulting address only moves when the capture strobe fires
  p_badaddr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.latchBad |=> $stable(badAddr));

  // in user mode status changes only through an exception or a return
  p_user_status_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (curUser && !ctl.takeExc && !ctl.doRet) |=> $stable(statusWord));

  // a return restores the previous pair
  p_ret_pops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.doRet |=> (stk[1:0] == $past(stk[3:2])));

  // the cause word carries nothing outside the code field
  p_cause_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    causeWord[CAUSE_LSB-1:0] == '0);

  // a request needs the global enable
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> stk[ST_IE_BIT]);

endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CODE_W = 5,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned IRQ_W  = 8,
  parameter logic [DATA_W-1:0] KREGION_BASE = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              excStrobe,
  input  logic [CODE_W-1:0] excCode,
  input  logic [DATA_W-1:0] excPc,
  input  logic [DATA_W-1:0] faultAddr,
  input  logic              faultAddrValid,
  input  logic              retStrobe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              kernelMode,
  input  logic [IRQ_W-1:0]  irqLines,
  output logic              irqReq
);

  excCtl_t ctl;
  logic    curUser;

  exc_ctrl_decode #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .KREGION_BASE(KREGION_BASE)
  ) u_decode (
    .clk(clk), .rst_n(rst_n),
    .excStrobe(excStrobe), .retStrobe(retStrobe),
    .regWrEn(regWrEn), .regSel(regSel),
    .faultAddrValid(faultAddrValid), .faultAddr(faultAddr),
    .curUser(curUser), .ctl(ctl)
  );

  exc_ctrl_dpath #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .SEL_W(SEL_W), .IRQ_W(IRQ_W)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .excCode(excCode), .excPc(excPc), .faultAddr(faultAddr),
    .regSel(regSel), .regWrData(regWrData), .irqLines(irqLines),
    .regRdData(regRdData), .curUser(curUser), .irqReq(irqReq)
  );

  assign kernelMode = !curUser;

endmodule

// File: tb/exc_ctrl_regs_tb.sv
module exc_ctrl_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        excStrobe = 1'b0;
  logic [4:0]  excCode = '0;
  logic [31:0] excPc = '0;
  logic [31:0] faultAddr = '0;
  logic        faultAddrValid = 1'b0;
  logic        retStrobe = 1'b0;
  logic [4:0]  regSel = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        kernelMode;
  logic [7:0]  irqLines = '0;
  logic        irqReq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  exc_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n),
    .excStrobe(excStrobe), .excCode(excCode), .excPc(excPc),
    .faultAddr(faultAddr), .faultAddrValid(faultAddrValid),
    .retStrobe(retStrobe), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .kernelMode(kernelMode), .irqLines(irqLines), .irqReq(irqReq)
  );

  // vector table: pc, code, address valid, fault address
  localparam int NV = 6;
  localparam logic [31:0] V_PC [NV] = '{32'h0040_0010, 32'h0040_0100, 32'h0040_0200,
                                        32'h0040_0FFC, 32'hFFFF_FFFC, 32'h0000_0000};
  localparam logic [4:0]  V_CODE [NV] = '{5'd12, 5'd4, 5'd7, 5'd10, 5'd4, 5'd0};
  localparam logic        V_VLD [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] V_ADDR [NV] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_0000,
                                          32'hFFFF_FFFC, 32'h9000_0000, 32'h0000_1000};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input int n, output logic [31:0] v);
    regSel = 5'(n);
    #1;
    v = regRdData;
  endtask

  // one event applied for exactly one rising edge
  task automatic pulse(input logic ex, input logic rt, input logic wr,
                       input logic [31:0] pc, input logic [4:0] code,
                       input logic vld, input logic [31:0] addr,
                       input int sel, input logic [31:0] wdata);
    @(negedge clk);
    excStrobe = ex; retStrobe = rt; regWrEn = wr;
    excPc = pc; excCode = code; faultAddrValid = vld; faultAddr = addr;
    regSel = 5'(sel); regWrData = wdata;
    @(negedge clk);
    excStrobe = 1'b0; retStrobe = 1'b0; regWrEn = 1'b0; faultAddrValid = 1'b0;
  endtask

  initial begin : watchdog
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: got=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] badModel;
    logic [5:0]  stkM;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irqLines = 8'hFF;
    @(negedge clk);

    // R1 reset state
    rd(8, v);  check("R1 faultaddr", v, 0);
    rd(12, v); check("R1 status", v, 0);
    rd(13, v); check("R1 cause", v, 0);
    rd(14, v); check("R1 retaddr", v, 0);
    check("R1 kernelMode", {31'b0, kernelMode}, 1);
    check("R1 irqReq", {31'b0, irqReq}, 0);

    // R8 kernel write keeps only the defined bits; enters user mode with ie
    pulse(0, 0, 1, 0, 0, 0, 0, 12, 32'hFFFF_FFFF);
    rd(12, v); check("R8 status write mask", v, 32'h0000_FF3F);
    check("R8 user mode after write", {31'b0, kernelMode}, 0);

    // R9 request gating
    irqLines = 8'h04; #1;
    check("R9 irq one line", {31'b0, irqReq}, 1);
    irqLines = 8'h00; #1;
    check("R9 irq none", {31'b0, irqReq}, 0);
    irqLines = 8'h81;

    // R8 user-mode write ignored
    pulse(0, 0, 1, 0, 0, 0, 0, 12, 32'h0000_0000);
    rd(12, v); check("R8 user write ignored", v, 32'h0000_FF3F);

    // R2 unmapped numbers
    rd(0, v);  check("R2 reg0", v, 0);
    rd(9, v);  check("R2 reg9", v, 0);
    rd(15, v); check("R2 reg15", v, 0);

    // table walk: exception from user mode, then return
    badModel = 32'h0;
    stkM = 6'h3F;
    for (int i = 0; i < NV; i++) begin
      pulse(1, 0, 0, V_PC[i], V_CODE[i], V_VLD[i], V_ADDR[i], 0, 0);
      if (V_VLD[i] && V_ADDR[i] >= 32'h8000_0000) badModel = V_ADDR[i];
      stkM = {stkM[3:0], 2'b00};
      rd(14, v); check($sformatf("R3 retaddr vec%0d", i), v, V_PC[i] + 32'd4);
      rd(13, v); check($sformatf("R4 cause vec%0d", i), v, {25'b0, V_CODE[i], 2'b00});
      rd(8, v);  check($sformatf("R5 faultaddr vec%0d", i), v, badModel);
      rd(12, v); check($sformatf("R6 status push vec%0d", i), v, {16'h0, 8'hFF, 2'b00, stkM});
      check($sformatf("R6 kernel vec%0d", i), {31'b0, kernelMode}, 1);
      check($sformatf("R6 irq off vec%0d", i), {31'b0, irqReq}, 0);
      pulse(0, 1, 0, 0, 0, 0, 0, 0, 0);
      stkM = {stkM[5:4], stkM[5:2]};
      rd(12, v); check($sformatf("R7 status pop vec%0d", i), v, {16'h0, 8'hFF, 2'b00, stkM});
      check($sformatf("R7 user again vec%0d", i), {31'b0, kernelMode}, 0);
    end

    // R6 nested exceptions; R5 no capture from kernel mode
    pulse(1, 0, 0, 32'h100, 5'd12, 1, 32'hA000_0000, 0, 0);
    rd(8, v); check("R5 user capture", v, 32'hA000_0000);
    pulse(1, 0, 0, 32'h200, 5'd4, 1, 32'hB000_0000, 0, 0);
    rd(8, v);  check("R5 kernel no capture", v, 32'hA000_0000);
    rd(12, v); check("R6 nested stack", v, 32'h0000_FF30);

    // R8 writes to read-only numbers ignored in kernel mode
    pulse(0, 0, 1, 0, 0, 0, 0, 14, 32'h1234_5678);
    rd(14, v); check("R8 retaddr read-only", v, 32'h204);
    pulse(0, 0, 1, 0, 0, 0, 0, 13, 32'hFFFF_FFFF);
    rd(13, v); check("R8 cause read-only", v, 32'h10);
    pulse(0, 0, 1, 0, 0, 0, 0, 8, 32'h0);
    rd(8, v);  check("R8 faultaddr read-only", v, 32'hA000_0000);

    // R10 exception beats return and write
    pulse(1, 1, 1, 32'h300, 5'd7, 0, 0, 12, 32'h0);
    regSel = 5'd12; #1;
    check("R10 exc wins status", regRdData, 32'h0000_FF00);
    rd(14, v); check("R10 exc wins retaddr", v, 32'h304);

    // R10 return beats write
    pulse(0, 1, 1, 0, 0, 0, 0, 12, 32'h0000_0003);
    rd(12, v); check("R10 ret wins over write", v, 32'h0000_FF00);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(8, v);  check("R1 re-reset faultaddr", v, 0);
    rd(12, v); check("R1 re-reset status", v, 0);
    rd(13, v); check("R1 re-reset cause", v, 0);
    rd(14, v); check("R1 re-reset retaddr", v, 0);
    check("R1 re-reset kernel", {31'b0, kernelMode}, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule